// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the two timing strobes a serial port needs from one system clock. The first is a sampling enable. The second is a bit enable. In synchronous operation it also drives a serial clock level with a balanced duty cycle. The source ticks come from one of three places: the system clock itself, the system clock after a fixed prescaler of `PRESC_DIV`, or rising edges of an external serial clock pin that has been synchronised. A 16-bit integer divisor counts source ticks. A 3-bit fraction in eighths lengthens some of those periods by one tick. A bit divider then turns sampling strobes into bit strobes. It divides by 16 or 8 in asynchronous mode, by 1 in synchronous mode, and by a programmable ratio in smart-card mode.

The divider is a four-state machine:
- `ST_IDLE`: the generator is off, either because the divisor is zero or because the reserved source is selected. Configuration is re-read every cycle.
- `ST_COUNT`: the machine counts divisor ticks.
- `ST_STRETCH`: the machine waits one extra tick at the end of a period that the fraction lengthens.
- `ST_PASS`: synchronous mode with the external clock. Every synchronised pin edge is forwarded and no division takes place.

Transitions out of the states:
- Every period end is a reload point. At a reload the machine latches the configuration inputs and moves to `ST_PASS`, `ST_IDLE` or `ST_COUNT`, chosen from the new settings.
- `ST_COUNT` moves to `ST_STRETCH` on its last tick when the phase accumulator has produced a carry.
- `ST_STRETCH` returns through a reload on its next tick.
- `ST_IDLE` and `ST_PASS` are reload points on every cycle.

Top module: `fbrg_top`

## Requirements
- R1: `clk_sel` picks the tick source. Code 0 is the system clock, with one tick per cycle. Code 1 is the system clock divided by `PRESC_DIV`. Code 3 is each synchronised rising edge of `ext_sck_in`. Code 2 is reserved: it keeps the generator in `ST_IDLE` with no `samp_en` pulses.
- R2: In asynchronous mode (`sync_mode`=0, `card_mode`=0), `samp_en` pulses once every `div_int` or `div_int`+1 ticks. Any 8 consecutive intervals add up to exactly 8·`div_int` + `div_frac` ticks.
- R3: In asynchronous mode `baud_en` pulses on every 16th `samp_en` pulse when `ovs8`=0 and on every 8th when `ovs8`=1. `baud_en` is only ever high together with `samp_en`.
- R4: `div_frac` has no effect in synchronous mode or in smart-card mode. There, every `samp_en` interval is exactly `div_int` ticks.
- R5: In synchronous mode with source code 0 or 1, `samp_en` and `baud_en` pulse together once every `div_int` ticks, with no oversampling division.
- R6: In synchronous mode with source code 3, each rising edge of `ext_sck_in` gives one `samp_en`/`baud_en` pulse, and `div_int`/`div_frac` have no effect. `sck_out` equals `ext_sck_in` delayed by two system clocks.
- R7: In synchronous mode with source code 0 and `div_int` ≥ 2, `sck_out` is high for exactly half of each period, measured in half system-clock cycles, for both odd and even `div_int`.
- R8: With source code 1 the period is `div_int`·`PRESC_DIV` system cycles. In synchronous mode `sck_out` is high for floor(`div_int`/2) ticks of each period.
- R9: In smart-card mode (`card_mode`=1, `sync_mode`=0), `baud_en` pulses on every `card_ratio`-th `samp_en` pulse.
- R10: `div_int`=0 outside synchronous external mode disables the generator: there are no `samp_en`/`baud_en` pulses and `sck_out` stays low.
- R11: Changes to configuration inputs take effect only at the end of the period in progress. That period completes with its old divisor.
- R12: While `rst_n` is low, `samp_en`, `baud_en` and `sck_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 2 | Tick source code (see R1) |
| div_int | input | 16 | Integer divisor; 0 turns the generator off |
| div_frac | input | 3 | Fraction in eighths, used in asynchronous mode only |
| ovs8 | input | 1 | 1 = 8 samples per bit, 0 = 16 |
| sync_mode | input | 1 | Synchronous operation |
| card_mode | input | 1 | Smart-card bit ratio in place of oversampling |
| card_ratio | input | 11 | Samples per bit in smart-card mode |
| ext_sck_in | input | 1 | External serial clock pin |
| samp_en | output | 1 | One-cycle sampling strobe |
| baud_en | output | 1 | One-cycle bit strobe |
| sck_out | output | 1 | Serial clock level in synchronous mode |

## Verification
The bench uses the default `PRESC_DIV` of 8. This keeps prescaled periods short enough to measure several whole periods at divisors up to 5. Because the divisors in the sweep are small (1 to 9), the bench can cover every fraction with both oversampling factors, and every odd and even divisor in synchronous mode. Duty is measured at half-cycle resolution, so the half-cycle balance for odd divisors is observed directly. Interval sums over 8 and 16 periods let the fractional distribution be checked exactly, whatever phase the accumulator starts from.

// File: rtl/fbrg_pkg.sv
package fbrg_pkg;
    localparam int CD_W    = 16;
    localparam int FP_W    = 3;
    localparam int RATIO_W = 11;

    typedef enum logic [1:0] {
        SRC_SYS = 2'd0,
        SRC_PRE = 2'd1,
        SRC_RSV = 2'd2,
        SRC_EXT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_STRETCH,
        ST_PASS
    } div_st_e;

    typedef struct packed {
        src_e                 sel;
        logic [CD_W-1:0]      cd;
        logic [FP_W-1:0]      fp;
        logic                 ovs8;
        logic                 sync;
        logic                 sc;
        logic [RATIO_W-1:0]   ratio;
    } cfg_t;
endpackage

// File: rtl/fbrg_src.sv
module fbrg_src import fbrg_pkg::*; #(
    parameter int PRESC_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  src_e sel,
    input  logic ext_pin,
    output logic tick,
    output logic ext_rise,
    output logic ext_lvl
);
    localparam int PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;

    logic [PW-1:0] pre_cnt;
    logic          pre_tick;
    logic [2:0]    sync_ff;

    assign pre_tick = (pre_cnt == PW'(PRESC_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            sync_ff <= '0;
        end else begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
            sync_ff <= {sync_ff[1:0], ext_pin};
        end
    end

    assign ext_lvl  = sync_ff[1];
    assign ext_rise = sync_ff[1] & ~sync_ff[2];

    always_comb begin
        unique case (sel)
            SRC_SYS: tick = 1'b1;
            SRC_PRE: tick = pre_tick;
            SRC_RSV: tick = 1'b0;
            SRC_EXT: tick = ext_rise;
        endcase
    end

    // R6: a synchronised pin edge lasts one cycle
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/fbrg_frac_div.sv
module fbrg_frac_div import fbrg_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  cfg_t               cfg_in,
    input  logic               tick,
    output src_e               cur_sel,
    output logic               cur_sync,
    output logic               cur_sc,
    output logic               cur_ovs8,
    output logic               cur_odd_sys,
    output logic [RATIO_W-1:0] cur_ratio,
    output div_st_e            st,
    output logic               per_end,
    output logic               lvl_q
);
    cfg_t            cfg_q, cfg_n;
    div_st_e         st_n;
    logic [CD_W-1:0] pos, pos_n;
    logic [FP_W-1:0] acc, acc_n, fp_eff, acc_base;
    logic [FP_W:0]   acc_sum;
    logic            stretch_q, stretch_n;
    logic            last_tick, div_end, reload, pass_w, off_w, lvl_n;

    assign last_tick = tick && (pos == cfg_q.cd - 1'b1);

    always_comb begin
        unique case (st)
            ST_COUNT:   div_end = last_tick && !stretch_q;
            ST_STRETCH: div_end = tick;
            default:    div_end = 1'b0;
        endcase
    end

    assign per_end  = div_end || (st == ST_PASS && tick);
    assign reload   = (st == ST_IDLE) || (st == ST_PASS) || div_end;
    assign pass_w   = cfg_in.sync && (cfg_in.sel == SRC_EXT);
    assign off_w    = (cfg_in.sel == SRC_RSV) || (cfg_in.cd == '0);
    assign fp_eff   = (cfg_in.sync || cfg_in.sc) ? '0 : cfg_in.fp;
    assign acc_base = (st == ST_COUNT || st == ST_STRETCH) ? acc : '0;
    assign acc_sum  = {1'b0, acc_base} + {1'b0, fp_eff};

    // next-state process
    always_comb begin
        st_n      = st;
        pos_n     = pos;
        acc_n     = acc;
        stretch_n = stretch_q;
        cfg_n     = cfg_q;
        if (reload) begin
            cfg_n = cfg_in;
            pos_n = '0;
            if (pass_w) begin
                st_n = ST_PASS;  acc_n = '0; stretch_n = 1'b0;
            end else if (off_w) begin
                st_n = ST_IDLE;  acc_n = '0; stretch_n = 1'b0;
            end else begin
                st_n      = ST_COUNT;
                acc_n     = acc_sum[FP_W-1:0];
                stretch_n = acc_sum[FP_W];
            end
        end else begin
            unique case (st)
                ST_COUNT: if (tick) begin
                    if (last_tick) st_n = ST_STRETCH;
                    else           pos_n = pos + 1'b1;
                end
                default: ;
            endcase
        end
        lvl_n = (st_n == ST_COUNT) && cfg_n.sync && (pos_n < (cfg_n.cd >> 1));
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            pos       <= '0;
            acc       <= '0;
            stretch_q <= 1'b0;
            cfg_q     <= '0;
            lvl_q     <= 1'b0;
        end else begin
            st        <= st_n;
            pos       <= pos_n;
            acc       <= acc_n;
            stretch_q <= stretch_n;
            cfg_q     <= cfg_n;
            lvl_q     <= lvl_n;
        end
    end

    assign cur_sel     = cfg_q.sel;
    assign cur_sync    = cfg_q.sync;
    assign cur_sc      = cfg_q.sc;
    assign cur_ovs8    = cfg_q.ovs8;
    assign cur_ratio   = cfg_q.ratio;
    assign cur_odd_sys = cfg_q.cd[0] && (cfg_q.sel == SRC_SYS);

    p_pos_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT) |-> (pos < cfg_q.cd));
    p_stretch_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRETCH && tick) |=> (st != ST_STRETCH));
    p_no_frac_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sync || cfg_q.sc) |-> (st != ST_STRETCH));
    p_rsv_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sel == SRC_RSV) |-> (st == ST_IDLE));
    p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.cd == '0 && st != ST_PASS) |-> !per_end);
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COUNT && !per_end) |=> $stable(cfg_q));
endmodule

// File: rtl/fbrg_bit_div.sv
module fbrg_bit_div import fbrg_pkg::*; (
    input  logic               clk,
    input  logic               rst_n,
    input  div_st_e            st,
    input  logic               per_end,
    input  logic               cur_sync,
    input  logic               cur_sc,
    input  logic               cur_ovs8,
    input  logic               cur_odd_sys,
    input  logic [RATIO_W-1:0] cur_ratio,
    input  logic               lvl_q,
    input  logic               ext_lvl,
    output logic               samp_en,
    output logic               baud_en,
    output logic               sck_out
);
    logic [RATIO_W-1:0] limit, bcnt;
    logic               wrap, lvl_neg;

    always_comb begin
        if (cur_sync)      limit = RATIO_W'(1);
        else if (cur_sc)   limit = cur_ratio;
        else if (cur_ovs8) limit = RATIO_W'(8);
        else               limit = RATIO_W'(16);
    end

    assign wrap = (bcnt >= limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt    <= '0;
            samp_en <= 1'b0;
            baud_en <= 1'b0;
        end else begin
            samp_en <= per_end;
            baud_en <= per_end && (limit != '0) && wrap;
            if (st == ST_IDLE)  bcnt <= '0;
            else if (per_end)   bcnt <= wrap ? '0 : bcnt + 1'b1;
        end
    end

    // half-cycle copy used to balance odd divisors on the system clock
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) lvl_neg <= 1'b0;
        else        lvl_neg <= lvl_q;
    end

    always_comb begin
        if (st == ST_PASS)    sck_out = ext_lvl;
        else if (cur_odd_sys) sck_out = lvl_q | lvl_neg;
        else                  sck_out = lvl_q;
    end

    p_baud_on_samp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        baud_en |-> samp_en);
    p_sync_equal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_en && $past(cur_sync)) |-> baud_en);
endmodule

// File: rtl/fbrg_top.sv
module fbrg_top import fbrg_pkg::*; #(
    parameter int PRESC_DIV = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  clk_sel,
    input  logic [15:0] div_int,
    input  logic [2:0]  div_frac,
    input  logic        ovs8,
    input  logic        sync_mode,
    input  logic        card_mode,
    input  logic [10:0] card_ratio,
    input  logic        ext_sck_in,
    output logic        samp_en,
    output logic        baud_en,
    output logic        sck_out
);
    cfg_t               cfg_in;
    src_e               cur_sel;
    logic               cur_sync, cur_sc, cur_ovs8, cur_odd_sys;
    logic [RATIO_W-1:0] cur_ratio;
    div_st_e            st;
    logic               tick, ext_rise, ext_lvl, per_end, lvl_q;

    always_comb begin
        cfg_in.sel   = src_e'(clk_sel);
        cfg_in.cd    = div_int;
        cfg_in.fp    = div_frac;
        cfg_in.ovs8  = ovs8;
        cfg_in.sync  = sync_mode;
        cfg_in.sc    = card_mode;
        cfg_in.ratio = card_ratio;
    end

    fbrg_src #(.PRESC_DIV(PRESC_DIV)) u_src (
        .clk(clk), .rst_n(rst_n), .sel(cur_sel), .ext_pin(ext_sck_in),
        .tick(tick), .ext_rise(ext_rise), .ext_lvl(ext_lvl)
    );

    fbrg_frac_div u_div (
        .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .tick(tick),
        .cur_sel(cur_sel), .cur_sync(cur_sync), .cur_sc(cur_sc),
        .cur_ovs8(cur_ovs8), .cur_odd_sys(cur_odd_sys), .cur_ratio(cur_ratio),
        .st(st), .per_end(per_end), .lvl_q(lvl_q)
    );

    fbrg_bit_div u_bit (
        .clk(clk), .rst_n(rst_n), .st(st), .per_end(per_end),
        .cur_sync(cur_sync), .cur_sc(cur_sc), .cur_ovs8(cur_ovs8),
        .cur_odd_sys(cur_odd_sys), .cur_ratio(cur_ratio),
        .lvl_q(lvl_q), .ext_lvl(ext_lvl),
        .samp_en(samp_en), .baud_en(baud_en), .sck_out(sck_out)
    );

    // R6: external ticks only reach the divider through the synchroniser
    p_ext_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_sel == SRC_EXT && tick) |-> $past(ext_lvl) == 1'b0);
endmodule

// File: tb/fbrg_top_tb_top.sv
module fbrg_top_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int P = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  clk_sel = '0;
    logic [15:0] div_int = '0;
    logic [2:0]  div_frac = '0;
    logic        ovs8 = 1'b0;
    logic        sync_mode = 1'b0;
    logic        card_mode = 1'b0;
    logic [10:0] card_ratio = '0;
    logic        ext_sck_in = 1'b0;
    logic        samp_en, baud_en, sck_out;

    int n_chk = 0;
    int n_bad = 0;
    bit ext_run = 1'b0;
    int ext_c = 0;

    fbrg_top #(.PRESC_DIV(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .div_int(div_int),
        .div_frac(div_frac), .ovs8(ovs8), .sync_mode(sync_mode),
        .card_mode(card_mode), .card_ratio(card_ratio), .ext_sck_in(ext_sck_in),
        .samp_en(samp_en), .baud_en(baud_en), .sck_out(sck_out)
    );

    always #5 clk = ~clk;

    // external pin: 5 cycles high, 5 low, changed away from the edge
    always begin
        @(posedge clk);
        #3;
        if (ext_run) begin
            ext_c++;
            if (ext_c == 5) begin
                ext_c = 0;
                ext_sck_in = ~ext_sck_in;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic setcfg(input int sel, input int cd, input int fp, input int ov,
                          input int syn, input int sc, input int ratio);
        clk_sel    = 2'(sel);
        div_int    = 16'(cd);
        div_frac   = 3'(fp);
        ovs8       = ov[0];
        sync_mode  = syn[0];
        card_mode  = sc[0];
        card_ratio = 11'(ratio);
    endtask

    // waits for a pulse, then sums the next n intervals in cycles
    task automatic meas(input bit pick_baud, input int n,
                        output int total, output int mn, output int mx);
        int c = 0;
        int got = -1;
        bit p;
        total = 0; mn = 1 << 30; mx = 0;
        for (int k = 0; k < 20000 && got < n; k++) begin
            @(posedge clk); #1;
            p = pick_baud ? baud_en : samp_en;
            c++;
            if (p) begin
                if (got >= 0) begin
                    total += c;
                    if (c < mn) mn = c;
                    if (c > mx) mx = c;
                end
                got++;
                c = 0;
            end
        end
        if (got < n) total = -1;
    endtask

    task automatic to_pulse(output int c);
        c = 0;
        for (int k = 0; k < 20000; k++) begin
            @(posedge clk); #1;
            c++;
            if (samp_en) break;
        end
    endtask

    task automatic duty(input int halves, output int hi);
        hi = 0;
        for (int i = 0; i < halves / 2; i++) begin
            @(posedge clk); #2; if (sck_out) hi++;
            @(negedge clk); #2; if (sck_out) hi++;
        end
    endtask

    task automatic quiet(input int cycles, output int pulses, output int highs);
        pulses = 0; highs = 0;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk); #1;
            if (samp_en || baud_en) pulses++;
            if (sck_out) highs++;
        end
    endtask

    initial begin
        #1900000;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    int t, mn, mx, hi, e, pl, c1, c2, mism;
    bit prev;

    initial begin
        setcfg(0, 3, 0, 0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(!samp_en && !baud_en && !sck_out, "R12 reset quiet",
            int'({samp_en, baud_en, sck_out}), 0);
        rst_n = 1'b1;

        // R2 / R3: asynchronous sweep over divisor, fraction and oversampling
        for (int ov = 0; ov < 2; ov++) begin
            for (int cd = 1; cd <= 6; cd++) begin
                for (int fp = 0; fp < 8; fp++) begin
                    setcfg(0, cd, fp, ov, 0, 0, 0);
                    meas(0, 3, t, mn, mx);
                    meas(0, 8, t, mn, mx);
                    chk(t == 8*cd + fp && mn >= cd && mx <= cd + 1,
                        "R2 fractional sum over 8", t, 8*cd + fp);
                    meas(1, 1, t, mn, mx);
                    e = (ov == 1) ? 8*cd + fp : 16*cd + 2*fp;
                    chk(t == e, "R3 oversampling bit interval", t, e);
                end
            end
        end

        // R5 / R4 / R7: synchronous on system clock, fraction set but ignored
        for (int cd = 2; cd <= 9; cd++) begin
            setcfg(0, cd, 5, 0, 1, 0, 0);
            meas(0, 2, t, mn, mx);
            meas(0, 4, t, mn, mx);
            chk(t == 4*cd && mn == cd && mx == cd, "R5 R4 sync period", t, 4*cd);
            meas(1, 2, t, mn, mx);
            chk(t == 2*cd, "R5 sync bit strobe", t, 2*cd);
            duty(8*cd, hi);
            chk(hi == 4*cd, "R7 half-cycle balance", hi, 4*cd);
        end

        // R8: prescaled source, synchronous
        for (int cd = 2; cd <= 5; cd++) begin
            setcfg(1, cd, 3, 0, 1, 0, 0);
            meas(0, 2, t, mn, mx);
            meas(0, 2, t, mn, mx);
            chk(t == 2*cd*P, "R8 prescaled period", t, 2*cd*P);
            duty(4*cd*P, hi);
            e = 2 * (cd / 2) * P * 2;
            chk(hi == e, "R8 prescaled duty", hi, e);
        end
        setcfg(1, 3, 0, 1, 0, 0, 0);
        meas(0, 2, t, mn, mx);
        meas(0, 2, t, mn, mx);
        chk(t == 2*3*P, "R8 prescaled async period", t, 2*3*P);

        // R9 / R4: smart-card ratio, fraction ignored
        for (int r = 3; r <= 7; r += 2) begin
            for (int cd = 2; cd <= 3; cd++) begin
                setcfg(0, cd, 6, 0, 0, 1, r);
                meas(0, 3, t, mn, mx);
                meas(0, 8, t, mn, mx);
                chk(t == 8*cd && mn == cd && mx == cd, "R4 card ignores fraction", t, 8*cd);
                meas(1, 1, t, mn, mx);
                chk(t == r*cd, "R9 card bit interval", t, r*cd);
            end
        end

        // R11: divisor change mid-period takes effect after the period
        setcfg(0, 12, 0, 0, 0, 0, 0);
        meas(0, 2, t, mn, mx);
        repeat (3) begin @(posedge clk); #1; end
        div_int = 16'd4;
        to_pulse(c1);
        chk(c1 == 9, "R11 old period completes", c1, 9);
        to_pulse(c2);
        chk(c2 == 4, "R11 new divisor next", c2, 4);

        // R1: reserved source
        setcfg(2, 5, 0, 0, 0, 0, 0);
        repeat (40) @(posedge clk);
        #1;
        quiet(300, pl, hi);
        chk(pl == 0, "R1 reserved source silent", pl, 0);

        // R10: zero divisor, async and sync
        setcfg(0, 0, 3, 0, 0, 0, 0);
        repeat (40) @(posedge clk);
        #1;
        quiet(300, pl, hi);
        chk(pl == 0 && hi == 0, "R10 zero divisor async", pl + hi, 0);
        setcfg(0, 0, 0, 0, 1, 0, 0);
        repeat (10) @(posedge clk);
        #1;
        quiet(300, pl, hi);
        chk(pl == 0 && hi == 0, "R10 zero divisor sync", pl + hi, 0);

        // R1: external edges as ticks in asynchronous mode, divisor 2
        ext_run = 1'b1;
        setcfg(3, 2, 0, 0, 0, 0, 0);
        meas(0, 2, t, mn, mx);
        meas(0, 4, t, mn, mx);
        chk(t == 80, "R1 external tick source", t, 80);

        // R6: synchronous pass-through, divisor and fraction ignored
        setcfg(3, 0, 5, 0, 1, 0, 0);
        repeat (40) @(posedge clk);
        #1;
        meas(0, 4, t, mn, mx);
        chk(t == 40 && mn == 10 && mx == 10, "R6 pass-through strobes", t, 40);
        meas(1, 2, t, mn, mx);
        chk(t == 20, "R6 pass-through bit strobe", t, 20);
        mism = 0;
        prev = ext_sck_in;
        for (int k = 0; k < 60; k++) begin
            @(posedge clk); #1;
            if (sck_out !== prev) mism++;
            prev = ext_sck_in;
        end
        chk(mism == 0, "R6 sck follows pin", mism, 0);
        ext_run = 1'b0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule